// File: doc/BRIEF.md
# Four-Channel Down-Counting Timer

This block is a memory-mapped timer with four independent down-counters that share one interrupt line. Software programs each channel with a start value, a reload value, a clock divider, a counter width and a mode. In one-shot mode a channel measures a single delay and then stops. In periodic mode it produces a steady event rate. In free-running mode it acts as a time base that software reads back and converts to an up-count by inverting it.

Every channel can raise an event when its count reaches zero. Events latch into a shared raw status register, one bit per channel. A mask register selects which latched bits reach the interrupt output. Software acknowledges an event by writing a one to that channel's bit in the clear register.

The register bus is a plain synchronous port: an address, write data and a write strobe, with read data returned one clock after the address is presented.

Top module: `dntimer_bank`

## Requirements
- R1: After reset every register reads 0 and `irq` is 0.
- R2: The shared registers are the mask at 0x00, raw status at 0x04, masked status at 0x08 and clear at 0x0C. Channel n (0..3) has its registers at 0x10+0x10*n: start value at +0x0, current count at +0x4, control at +0x8 and reload at +0xC. `bus_rdata` holds the word at the address presented one clock earlier. Writes to raw status, masked status and current count have no effect, and the start value reads back exactly as written.
- R3: Control bit 7 enables the channel. While bit 7 is 0 the current count does not change, so writing 0 to control stops the channel.
- R4: Control bits 3:2 set the divider. 00 gives one count step per clock, 01 one step per 16 clocks, and 10 or 11 one step per 256 clocks. The divider restarts whenever the channel is disabled, so the first step falls on the 1st, 16th or 256th clock after the enabling write.
- R5: A write to the start value also sets the reload value. The current count takes the start value (masked to the counter width) on the channel's next count step.
- R6: With control bit 0 set (one-shot), a start value N loaded in an idle channel sets the raw bit after N+1 count steps. The count then holds at 0 and raises no further events until a new start value is written.
- R7: With bit 0 clear and bit 6 set (periodic), a step taken at count 0 reloads the reload value. A reload write made mid-period changes only the periods that start after the next zero.
- R8: With bits 0 and 6 clear (free-running), a step taken at count 0 wraps the count to all ones of the selected width.
- R9: Control bit 1 selects a 32-bit count. When bit 1 is 0, the count, its reload and its wrap are limited to 16 bits.
- R10: Raw bit n sets when channel n steps down to 0 in any mode. Writing 1 to bit n of the clear register clears it. If a set and a clear fall in the same clock, the bit stays set.
- R11: Masked status equals raw AND mask. `irq` is the OR of masked status, registered, and follows it by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and all counters |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one clock per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the address |
| irq | output | 1 | Registered OR of the masked status bits |

## Verification
The bench measures one-shot delays in exact clocks for every divider code, including the 11 code, and for every channel. An off-by-one in the load step or the divider phase would shift the first interrupt by one clock or by a whole divider period. It traces the count every clock through periodic reloads, a mid-period reload change and 16-bit and 32-bit wraps. A design that applied the reload at once, wrapped to the wrong width or kept upper bits in 16-bit mode would break the expected sequence. It also places an acknowledge on the exact clock of an event, where a design that let the clear win would lose the interrupt. Finally it sweeps all sixteen masks against a fixed raw pattern.

// File: rtl/dntimer_pkg.sv
package dntimer_pkg;

  // word select inside a 16-byte block
  localparam logic [1:0] W_START = 2'd0;
  localparam logic [1:0] W_COUNT = 2'd1;
  localparam logic [1:0] W_CTRL  = 2'd2;
  localparam logic [1:0] W_RELOAD = 2'd3;

  localparam logic [1:0] S_MASK  = 2'd0;
  localparam logic [1:0] S_RAW   = 2'd1;
  localparam logic [1:0] S_MSKD  = 2'd2;
  localparam logic [1:0] S_ACK   = 2'd3;

  // control byte, bit order is what software writes
  typedef struct packed {
    logic       en;     // 7
    logic       per;    // 6
    logic [1:0] rsv;    // 5:4
    logic [1:0] ps;     // 3:2
    logic       wide;   // 1
    logic       one;    // 0
  } ctrl_t;

  localparam logic [7:0] CTRL_KEEP = 8'hCF;

  typedef enum logic [1:0] {
    MODE_FREE     = 2'd0,
    MODE_PERIODIC = 2'd1,
    MODE_ONESHOT  = 2'd2
  } mode_e;

endpackage

// File: rtl/dntimer_prescaler.sv
module dntimer_prescaler #(
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] sel,
  output logic       tick
);
  localparam int PW = HI_LOG2;
  localparam logic [PW-1:0] LIM_MID = PW'((1 << MID_LOG2) - 1);
  localparam logic [PW-1:0] LIM_HI  = PW'((1 << HI_LOG2) - 1);

  logic [PW-1:0] cnt;
  logic [PW-1:0] lim;

  always_comb begin
    case (sel)
      2'b00:   lim = '0;
      2'b01:   lim = LIM_MID;
      default: lim = LIM_HI;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !en)      cnt <= '0;
    else if (cnt >= lim) cnt <= '0;
    else                 cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt >= lim);

endmodule

// File: rtl/dntimer_channel.sv
module dntimer_channel
  import dntimer_pkg::*;
#(
  parameter int CW = 32,
  parameter int NW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_start,
  input  logic          wr_ctrl,
  input  logic          wr_reload,
  input  logic [CW-1:0] wdata,
  input  logic          tick,
  output ctrl_t         ctrl_q,
  output logic [CW-1:0] start_q,
  output logic [CW-1:0] reload_q,
  output logic [CW-1:0] count_q,
  output logic          evt
);
  localparam logic [CW-1:0] NARROW = {{(CW-NW){1'b0}}, {NW{1'b1}}};

  ctrl_t         ctrl_r;
  logic          pend_r;
  logic [CW-1:0] start_r, reload_r, count_r;
  logic [CW-1:0] count_nx, wmask, dec;
  mode_e         mode;

  always_comb begin
    if (ctrl_r.one)      mode = MODE_ONESHOT;
    else if (ctrl_r.per) mode = MODE_PERIODIC;
    else                 mode = MODE_FREE;
  end

  assign wmask = ctrl_r.wide ? {CW{1'b1}} : NARROW;
  assign dec   = (count_r - 1'b1) & wmask;

  always_comb begin
    count_nx = count_r;
    evt      = 1'b0;
    if (tick) begin
      if (pend_r) begin
        count_nx = start_r & wmask;
      end else if (count_r == '0) begin
        case (mode)
          MODE_ONESHOT:  count_nx = '0;
          MODE_PERIODIC: count_nx = reload_r & wmask;
          default:       count_nx = wmask;
        endcase
      end else begin
        count_nx = dec;
        evt      = (dec == '0);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_r   <= '0;
      pend_r   <= 1'b0;
      start_r  <= '0;
      reload_r <= '0;
      count_r  <= '0;
    end else begin
      if (wr_ctrl) ctrl_r <= ctrl_t'(wdata[7:0] & CTRL_KEEP);
      if (wr_start) begin
        start_r  <= wdata;
        reload_r <= wdata;
      end else if (wr_reload) begin
        reload_r <= wdata;
      end
      if (wr_start)  pend_r <= 1'b1;
      else if (tick) pend_r <= 1'b0;
      count_r <= count_nx;
    end
  end

  assign ctrl_q   = ctrl_r;
  assign start_q  = start_r;
  assign reload_q = reload_r;
  assign count_q  = count_r;

endmodule

// File: rtl/dntimer_irqctl.sv
module dntimer_irqctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] evt,
  input  logic           wr_mask,
  input  logic           wr_ack,
  input  logic [NCH-1:0] wdata,
  output logic [NCH-1:0] mask_q,
  output logic [NCH-1:0] raw_q,
  output logic           irq
);
  logic [NCH-1:0] ack;

  assign ack = wr_ack ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      raw_q  <= '0;
      irq    <= 1'b0;
    end else begin
      if (wr_mask) mask_q <= wdata;
      raw_q <= (raw_q & ~ack) | evt;
      irq   <= |(raw_q & mask_q);
    end
  end

endmodule

// File: rtl/dntimer_bank.sv
module dntimer_bank
  import dntimer_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int CW       = 32,
  parameter int NW       = 16,
  parameter int AW       = 8,
  parameter int MID_LOG2 = 4,
  parameter int HI_LOG2  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  output logic          irq
);
  localparam int BW = AW - 4;

  logic [BW-1:0] blk;
  logic [1:0]    wsel;
  logic          shared_hit;
  logic          unused_addr_lo;

  assign blk            = bus_addr[AW-1:4];
  assign wsel           = bus_addr[3:2];
  assign shared_hit     = (blk == '0);
  assign unused_addr_lo = ^bus_addr[1:0];

  logic [NCH-1:0]         hit, tick, evt, en_v;
  ctrl_t [NCH-1:0]        ctrl_a;
  logic [NCH-1:0][CW-1:0] start_a, reload_a, count_a;
  logic [NCH-1:0]         mask_q, raw_q;
  logic                   wr_mask, wr_ack;

  assign wr_mask = bus_we && shared_hit && (wsel == S_MASK);
  assign wr_ack  = bus_we && shared_hit && (wsel == S_ACK);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit[i]  = (blk == BW'(i + 1));
    assign en_v[i] = ctrl_a[i].en;

    dntimer_prescaler #(
      .MID_LOG2(MID_LOG2),
      .HI_LOG2 (HI_LOG2)
    ) u_ps (
      .clk (clk),
      .rst (rst),
      .en  (ctrl_a[i].en),
      .sel (ctrl_a[i].ps),
      .tick(tick[i])
    );

    dntimer_channel #(
      .CW(CW),
      .NW(NW)
    ) u_ch (
      .clk      (clk),
      .rst      (rst),
      .wr_start (bus_we && hit[i] && (wsel == W_START)),
      .wr_ctrl  (bus_we && hit[i] && (wsel == W_CTRL)),
      .wr_reload(bus_we && hit[i] && (wsel == W_RELOAD)),
      .wdata    (bus_wdata),
      .tick     (tick[i]),
      .ctrl_q   (ctrl_a[i]),
      .start_q  (start_a[i]),
      .reload_q (reload_a[i]),
      .count_q  (count_a[i]),
      .evt      (evt[i])
    );
  end

  dntimer_irqctl #(.NCH(NCH)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .evt    (evt),
    .wr_mask(wr_mask),
    .wr_ack (wr_ack),
    .wdata  (bus_wdata[NCH-1:0]),
    .mask_q (mask_q),
    .raw_q  (raw_q),
    .irq    (irq)
  );

  logic [CW-1:0] rd_nx;

  always_comb begin
    rd_nx = '0;
    if (shared_hit) begin
      case (wsel)
        S_MASK:  rd_nx = CW'(mask_q);
        S_RAW:   rd_nx = CW'(raw_q);
        S_MSKD:  rd_nx = CW'(raw_q & mask_q);
        default: rd_nx = '0;
      endcase
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (hit[i]) begin
          case (wsel)
            W_START: rd_nx = start_a[i];
            W_COUNT: rd_nx = count_a[i];
            W_CTRL:  rd_nx = CW'(ctrl_a[i]);
            default: rd_nx = reload_a[i];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= rd_nx;
  end

endmodule

// File: rtl/dntimer_bank_chk.sv
module dntimer_bank_chk #(
  parameter int NCH = 4,
  parameter int CW  = 32,
  parameter int AW  = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   bus_we,
  input logic [AW-1:0]          bus_addr,
  input logic [CW-1:0]          bus_wdata,
  input logic                   irq,
  input logic [NCH-1:0]         raw_q,
  input logic [NCH-1:0]         mask_q,
  input logic [NCH-1:0]         evt,
  input logic [NCH-1:0]         tick,
  input logic [NCH-1:0]         en_v,
  input logic [NCH-1:0][CW-1:0] count_a
);
  logic ack_wr;
  assign ack_wr = bus_we && ((bus_addr & ~AW'(3)) == AW'(12));

  // R11: irq is the registered OR of raw AND mask
  a_r11_irq_or: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == |($past(raw_q) & $past(mask_q))));

  for (genvar i = 0; i < NCH; i++) begin : g_p
    // R3: a disabled channel keeps its count
    a_r3_frozen_when_off: assert property (@(posedge clk) disable iff (rst)
      !en_v[i] |=> (count_a[i] == $past(count_a[i])));

    // R4: the divider steps only an enabled channel
    a_r4_tick_needs_enable: assert property (@(posedge clk) disable iff (rst)
      tick[i] |-> en_v[i]);

    // R10: an acknowledge with no event clears the bit
    a_r10_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (ack_wr && bus_wdata[i] && !evt[i]) |=> !raw_q[i]);

    // R10: an event sets the bit even with an acknowledge in the same clock
    a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
      evt[i] |=> raw_q[i]);
  end

endmodule

bind dntimer_bank dntimer_bank_chk #(
  .NCH(NCH),
  .CW (CW),
  .AW (AW)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .bus_wdata(bus_wdata),
  .irq      (irq),
  .raw_q    (raw_q),
  .mask_q   (mask_q),
  .evt      (evt),
  .tick     (tick),
  .en_v     (en_v),
  .count_a  (count_a)
);

// File: tb/dntimer_bank_test.sv
module dntimer_bank_test;
  localparam int NCH = 4;
  localparam int CW  = 32;
  localparam int AW  = 8;

  localparam logic [AW-1:0] A_MASK = 8'h00;
  localparam logic [AW-1:0] A_RAW  = 8'h04;
  localparam logic [AW-1:0] A_MSKD = 8'h08;
  localparam logic [AW-1:0] A_ACK  = 8'h0C;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic [CW-1:0] bus_wdata = '0;
  logic [CW-1:0] bus_rdata;
  logic          irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [CW-1:0] s [0:31];

  always #5 clk = ~clk;

  dntimer_bank #(.NCH(NCH), .CW(CW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [AW-1:0] ch_addr(int ch, int w);
    return AW'(16 + 16 * ch + 4 * w);
  endfunction

  task automatic check(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(logic [AW-1:0] a, logic [CW-1:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [CW-1:0] d);
    bus_addr = a; bus_we = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic watch(int ch, int n);
    bus_addr = ch_addr(ch, 1); bus_we = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      s[i] = bus_rdata;
    end
  endtask

  task automatic verify_seq(string req, int n, int from, logic [CW-1:0] reload);
    bit bad = 1'b0;
    logic [CW-1:0] a = '0, e = '0;
    for (int i = from + 1; i < n; i++) begin
      if (!bad) begin
        e = (s[i-1] == '0) ? reload : s[i-1] - 1;
        if (s[i] !== e) begin bad = 1'b1; a = s[i]; end
      end
    end
    if (bad) check(req, a, e);
    else     check(req, '0, '0);
  endtask

  task automatic stop_all();
    for (int c = 0; c < NCH; c++) wr(ch_addr(c, 2), '0);
    wr(A_ACK, 32'hF);
  endtask

  task automatic oneshot_delay(int ch, int ps, int n, int div);
    int k = 0;
    logic [CW-1:0] d;
    wr(ch_addr(ch, 2), '0);
    wr(A_ACK, 32'hF);
    wr(ch_addr(ch, 0), CW'(n));
    wr(A_MASK, CW'(1 << ch));
    wr(ch_addr(ch, 2), CW'(32'h83 | (ps << 2)));
    while (!irq && k < 5000) begin @(negedge clk); k++; end
    check($sformatf("R6 R4 delay ch%0d ps%0d", ch, ps), CW'(k), CW'(div * (n + 1) + 1));
    rd(A_RAW, d);
    check("R10 raw bit of channel", CW'(d[ch]), CW'(1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [CW-1:0] d, d2;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state of every register
    for (int a = 0; a < 20; a++) begin
      rd(AW'(4 * a), d);
      check($sformatf("R1 reset value at %0h", 4 * a), d, '0);
    end
    check("R1 irq low after reset", CW'(irq), '0);

    // R4 R6: one-shot delay over every divider code
    oneshot_delay(1, 0, 5, 1);
    oneshot_delay(1, 1, 3, 16);
    oneshot_delay(1, 2, 2, 256);
    oneshot_delay(1, 3, 2, 256);
    // R2: every channel decodes at its own block
    for (int c = 0; c < NCH; c++) oneshot_delay(c, 0, 3 + c, 1);

    // R6: count holds at zero, no second event
    repeat (40) @(negedge clk);
    rd(ch_addr(3, 1), d);
    check("R6 one-shot holds at zero", d, '0);
    wr(A_ACK, 32'h8);
    repeat (40) @(negedge clk);
    rd(A_RAW, d);
    check("R6 no further event after ack", CW'(d[3]), '0);
    check("R10 irq low after ack", CW'(irq), '0);

    // R10: event and ack in the same clock, event stays
    stop_all();
    wr(ch_addr(1, 0), 32'd6);
    wr(ch_addr(1, 2), 32'h83);
    repeat (6) @(negedge clk);
    wr(A_ACK, 32'h2);
    rd(A_RAW, d);
    check("R10 set wins over same-clock ack", CW'(d[1]), CW'(1));
    wr(A_ACK, 32'h2);
    rd(A_RAW, d);
    check("R10 ack clears raw bit", CW'(d[1]), '0);

    // R7: periodic reload
    stop_all();
    wr(ch_addr(2, 0), 32'd4);
    wr(ch_addr(2, 2), 32'hC2);
    watch(2, 16);
    check("R5 start value taken on first step", s[1], 32'd4);
    verify_seq("R7 periodic sequence reload 4", 16, 1, 32'd4);
    rd(A_RAW, d);
    check("R10 periodic sets raw", CW'(d[2]), CW'(1));
    wr(ch_addr(2, 3), 32'd7);
    watch(2, 20);
    check("R7 reload change waits for zero", CW'(s[0] <= 32'd4), CW'(1));
    verify_seq("R7 sequence after reload change", 20, 0, 32'd7);
    wr(ch_addr(2, 0), 32'd100);
    watch(2, 4);
    check("R5 new start value on next step", s[1], 32'd100);
    check("R5 count continues down", s[2], 32'd99);
    rd(ch_addr(2, 3), d);
    check("R5 start write sets reload", d, 32'd100);

    // R8 R9: free-running wraps
    stop_all();
    wr(ch_addr(3, 0), 32'd2);
    wr(ch_addr(3, 2), 32'h80);
    watch(3, 8);
    check("R8 free-run 16-bit wrap value", s[4], 32'h0000FFFF);
    verify_seq("R8 R9 free-run 16-bit sequence", 8, 1, 32'h0000FFFF);
    wr(ch_addr(0, 0), 32'd1);
    wr(ch_addr(0, 2), 32'h82);
    watch(0, 6);
    check("R8 free-run 32-bit wrap value", s[3], 32'hFFFFFFFF);
    verify_seq("R8 free-run 32-bit sequence", 6, 1, 32'hFFFFFFFF);

    // R9: narrow width masks the start value
    stop_all();
    wr(ch_addr(3, 0), 32'h00012345);
    wr(ch_addr(3, 2), 32'h81);
    watch(3, 3);
    check("R9 16-bit start value masked", s[1], 32'h00002345);
    rd(ch_addr(3, 0), d);
    check("R2 start value reads back as written", d, 32'h00012345);
    rd(ch_addr(3, 2), d);
    check("R2 control reads back", d, 32'h00000081);

    // R3: stop freezes the count
    wr(ch_addr(3, 2), '0);
    rd(ch_addr(3, 1), d);
    repeat (10) @(negedge clk);
    rd(ch_addr(3, 1), d2);
    check("R3 stopped count frozen", d2, d);
    check("R3 frozen count not zero", CW'(d2 != '0), CW'(1));
    wr(ch_addr(3, 1), 32'h55);
    rd(ch_addr(3, 1), d2);
    check("R2 write to count ignored", d2, d);

    // R11: mask sweep over a fixed raw pattern 1001
    stop_all();
    wr(A_MASK, '0);
    wr(ch_addr(0, 0), 32'd1);
    wr(ch_addr(3, 0), 32'd1);
    wr(ch_addr(0, 2), 32'h83);
    wr(ch_addr(3, 2), 32'h83);
    repeat (10) @(negedge clk);
    wr(A_RAW, 32'hF);
    rd(A_RAW, d);
    check("R2 R10 raw pattern, raw write ignored", d, 32'h9);
    for (int m = 0; m < 16; m++) begin
      wr(A_MASK, CW'(m));
      rd(A_MSKD, d);
      check($sformatf("R11 masked status m=%0d", m), d, CW'(m & 9));
      check($sformatf("R11 irq m=%0d", m), CW'(irq), CW'((m & 9) != 0));
      rd(A_MASK, d);
      check($sformatf("R2 mask readback m=%0d", m), d, CW'(m));
    end
    wr(A_ACK, 32'h1);
    rd(A_RAW, d);
    check("R10 ack one bit leaves others", d, 32'h8);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule